// File: doc/BRIEF.md
# Sampling-Phase Eye-Centering Calibrator

This block finds the best sampling phase for one deserialized serial link. The capture clock of the link has a phase shifter that moves in 256 equal steps across one slow-clock period. At 45 MHz one step is roughly 87 ps. The block drives that shifter through a step pulse with a direction bit and waits for an acknowledge after every step. At each setting it compares incoming words against a fixed training pattern and decides whether the setting is clean.

After a start request the block first finds a clean setting. It then walks downward until the data fails, which gives the lower edge of the data eye. It then walks upward past its first clean setting until the data fails again, which gives the upper edge. It parks the phase at the middle of the clean window, raises a done flag and keeps that setting. If the window is missing or too narrow, it returns the phase to where it started and raises a fail flag instead. Every link has its own instance, so each link settles on its own phase value. Phase values wrap modulo 256, so a window that crosses from 255 to 0 is handled like any other window.

Top module: `phase_eye_cal`

## Requirements
- R1: After reset, step_o, done_o, fail_o and busy_o are low and phase_o is 0.
- R2: A step is a single-cycle step_o pulse, with step_up_o high meaning +1 and low meaning -1. No further step is issued until step_ack_i returns. phase_o changes by exactly that step, modulo 256, one cycle after the acknowledge, and it always equals the shifter's true position.
- R3: A setting is clean only when 64 consecutive valid words all equal the training pattern 7'h63. Any mismatch makes the setting bad. Words presented with word_valid_i low are ignored and do not advance the test.
- R4: If the phase at the start request is bad, the block steps upward, testing each setting in turn, until it reaches the first clean setting.
- R5: From a clean setting the block finds the lowest and the highest clean settings of the contiguous window. It parks at lower + floor((width-1)/2) modulo 256, with done_o high and fail_o low.
- R6: A window that crosses from 255 to 0 is measured and centred correctly, modulo 256.
- R7: A window narrower than 8 settings ends with done_o and fail_o high and phase_o back at its value at the start request. A window of exactly 8 succeeds.
- R8: If none of the 256 settings is clean, the block ends with done_o and fail_o high and phase_o back at its start value.
- R9: If all 256 settings are clean, the block parks at the start value + 128 modulo 256, and fail_o stays low.
- R10: Once done_o is high, it stays high. phase_o and fail_o hold their values, no step is issued, and further start requests are ignored until reset.
- R11: busy_o is high from the cycle after an accepted start until the end of calibration. It is never high together with done_o, and steps only occur while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start calibration request |
| word_i | input | 7 | Received deserialized word |
| word_valid_i | input | 1 | word_i carries a valid word this cycle |
| step_ack_i | input | 1 | Phase shifter finished the requested step |
| step_o | output | 1 | One-cycle phase step request |
| step_up_o | output | 1 | Step direction, 1 = increment, 0 = decrement |
| phase_o | output | 8 | Tracked phase setting; the chosen phase once done |
| done_o | output | 1 | Calibration has ended |
| fail_o | output | 1 | Calibration ended without a usable window |
| busy_o | output | 1 | Calibration in progress |

## Verification
The bench models a link whose data is clean on a chosen arc of settings. Runs cover the following cases:
- A window away from the start, which exercises the upward search.
- A window that straddles 255-to-0 and contains the start.
- Windows of 8 and 7 settings, which probe the width limit.
- No clean setting at all.
- The whole circle clean.

One run adds a marginal setting just above the window that corrupts one word in 40. That setting must be rejected, and accepting it would shift the centre by one. Valid-strobe gaps carry garbage words throughout. One run holds the strobe low long enough to show that no decision or step is taken without valid words. Random acknowledge latency checks that phase tracking never slips against the modelled shifter.

// File: rtl/phase_eye_cal_pkg.sv
package phase_eye_cal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TEST,
      ST_STEP_WAIT,
      ST_MOVE,
      ST_PLAN,
      ST_DONE
   } cal_state_t;

   typedef enum logic [1:0] {
      SW_SEARCH,
      SW_LOWER,
      SW_UPPER
   } sweep_t;

endpackage

// File: rtl/eye_word_matcher.sv
module eye_word_matcher #(
   parameter int               WORD_W    = 7,
   parameter int               RUN_LEN   = 64,
   parameter bit               REG_INPUT = 1'b0,
   parameter logic [WORD_W-1:0] PATTERN  = 7'h63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              clear_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              valid_i,
   output logic              pass_o,
   output logic              miss_o
);
   localparam int CNT_W = $clog2(RUN_LEN + 1);

   logic [WORD_W-1:0] s_word;
   logic              s_valid;
   logic [CNT_W-1:0]  run_cnt;

   generate
      if (REG_INPUT) begin : g_staged
         always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
               s_word  <= '0;
               s_valid <= 1'b0;
            end else begin
               s_word  <= word_i;
               s_valid <= valid_i;
            end
         end
      end else begin : g_direct
         assign s_word  = word_i;
         assign s_valid = valid_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         run_cnt <= '0;
         pass_o  <= 1'b0;
         miss_o  <= 1'b0;
      end else if (en_i && s_valid && !pass_o && !miss_o) begin
         if (s_word == PATTERN) begin
            run_cnt <= run_cnt + CNT_W'(1);
            if (run_cnt == CNT_W'(RUN_LEN - 1))
               pass_o <= 1'b1;
         end else begin
            miss_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/phase_step_tracker.sv
module phase_step_tracker #(
   parameter int PH_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic            req_up_i,
   input  logic            ack_i,
   output logic            step_o,
   output logic            step_up_o,
   output logic            pending_o,
   output logic            stepped_o,
   output logic [PH_W-1:0] phase_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_o    <= 1'b0;
         step_up_o <= 1'b0;
         pending_o <= 1'b0;
         stepped_o <= 1'b0;
         phase_o   <= '0;
      end else begin
         step_o    <= 1'b0;
         stepped_o <= 1'b0;
         if (pending_o) begin
            if (ack_i) begin
               pending_o <= 1'b0;
               stepped_o <= 1'b1;
               phase_o   <= step_up_o ? phase_o + PH_W'(1) : phase_o - PH_W'(1);
            end
         end else if (req_i) begin
            step_o    <= 1'b1;
            step_up_o <= req_up_i;
            pending_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/eye_sweep_ctrl.sv
module eye_sweep_ctrl
   import phase_eye_cal_pkg::*;
#(
   parameter int PH_W      = 8,
   parameter int MIN_WIDTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            pass_i,
   input  logic            miss_i,
   input  logic            stepped_i,
   input  logic [PH_W-1:0] cur_i,
   output logic            req_o,
   output logic            req_up_o,
   output logic            clear_o,
   output logic            test_en_o,
   output logic            busy_o,
   output logic            done_o,
   output logic            fail_o
);
   localparam int NPH = 1 << PH_W;
   localparam int CW  = PH_W + 1;

   cal_state_t      state;
   sweep_t          sweep;
   logic [PH_W-1:0] start_ph, good_ph, target;
   logic [CW-1:0]   cnt_lo, cnt_hi;
   logic            go_test, in_move, fail_q, req_q, req_up_q, clr_q;

   logic [CW-1:0]   width, half_w;
   logic [PH_W-1:0] lower, mid, diff;
   logic            move_up, verdict;

   // window geometry from the edge counters
   assign width   = cnt_lo + cnt_hi + CW'(1);
   assign half_w  = (width - CW'(1)) >> 1;
   assign lower   = good_ph - cnt_lo[PH_W-1:0];
   assign mid     = lower + half_w[PH_W-1:0];
   assign diff    = target - cur_i;
   assign move_up = ({1'b0, diff} <= CW'(NPH / 2));
   assign verdict = !clr_q && (pass_i || miss_i);

   assign req_o     = req_q;
   assign req_up_o  = req_up_q;
   assign clear_o   = clr_q;
   assign test_en_o = (state == ST_TEST);
   assign busy_o    = (state != ST_IDLE) && (state != ST_DONE);
   assign done_o    = (state == ST_DONE);
   assign fail_o    = (state == ST_DONE) && fail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sweep    <= SW_SEARCH;
         start_ph <= '0;
         good_ph  <= '0;
         target   <= '0;
         cnt_lo   <= '0;
         cnt_hi   <= '0;
         go_test  <= 1'b0;
         in_move  <= 1'b0;
         fail_q   <= 1'b0;
         req_q    <= 1'b0;
         req_up_q <= 1'b0;
         clr_q    <= 1'b0;
      end else begin
         req_q <= 1'b0;
         clr_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  start_ph <= cur_i;
                  sweep    <= SW_SEARCH;
                  cnt_lo   <= '0;
                  cnt_hi   <= '0;
                  fail_q   <= 1'b0;
                  clr_q    <= 1'b1;
                  state    <= ST_TEST;
               end
            end
            ST_TEST: begin
               if (verdict) begin
                  case (sweep)
                     SW_SEARCH: begin
                        if (pass_i) begin
                           good_ph  <= cur_i;
                           cnt_hi   <= '0;
                           sweep    <= SW_LOWER;
                           req_q    <= 1'b1;
                           req_up_q <= 1'b0;
                           in_move  <= 1'b0;
                           state    <= ST_STEP_WAIT;
                        end else if (cnt_hi == CW'(NPH - 1)) begin
                           fail_q  <= 1'b1;
                           target  <= start_ph;
                           go_test <= 1'b0;
                           state   <= ST_MOVE;
                        end else begin
                           cnt_hi   <= cnt_hi + CW'(1);
                           req_q    <= 1'b1;
                           req_up_q <= 1'b1;
                           in_move  <= 1'b0;
                           state    <= ST_STEP_WAIT;
                        end
                     end
                     SW_LOWER: begin
                        if (pass_i) begin
                           cnt_lo <= cnt_lo + CW'(1);
                           if (cnt_lo == CW'(NPH - 2)) begin
                              state <= ST_PLAN;
                           end else begin
                              req_q    <= 1'b1;
                              req_up_q <= 1'b0;
                              in_move  <= 1'b0;
                              state    <= ST_STEP_WAIT;
                           end
                        end else begin
                           sweep   <= SW_UPPER;
                           target  <= good_ph + PH_W'(1);
                           go_test <= 1'b1;
                           state   <= ST_MOVE;
                        end
                     end
                     default: begin
                        if (pass_i) begin
                           cnt_hi   <= cnt_hi + CW'(1);
                           req_q    <= 1'b1;
                           req_up_q <= 1'b1;
                           in_move  <= 1'b0;
                           state    <= ST_STEP_WAIT;
                        end else begin
                           state <= ST_PLAN;
                        end
                     end
                  endcase
               end
            end
            ST_PLAN: begin
               if (width < CW'(MIN_WIDTH)) begin
                  fail_q <= 1'b1;
                  target <= start_ph;
               end else begin
                  target <= mid;
               end
               go_test <= 1'b0;
               state   <= ST_MOVE;
            end
            ST_MOVE: begin
               if (cur_i == target) begin
                  if (go_test) begin
                     clr_q <= 1'b1;
                     state <= ST_TEST;
                  end else begin
                     state <= ST_DONE;
                  end
               end else begin
                  req_q    <= 1'b1;
                  req_up_q <= move_up;
                  in_move  <= 1'b1;
                  state    <= ST_STEP_WAIT;
               end
            end
            ST_STEP_WAIT: begin
               if (stepped_i) begin
                  if (in_move) begin
                     state <= ST_MOVE;
                  end else begin
                     clr_q <= 1'b1;
                     state <= ST_TEST;
                  end
               end
            end
            default: state <= ST_DONE;
         endcase
      end
   end

endmodule

// File: rtl/phase_eye_cal.sv
module phase_eye_cal #(
   parameter int                WORD_W    = 7,
   parameter int                PH_W      = 8,
   parameter int                RUN_LEN   = 64,
   parameter int                MIN_WIDTH = 8,
   parameter bit                REG_INPUT = 1'b0,
   parameter logic [WORD_W-1:0] PATTERN   = 7'h63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              word_valid_i,
   input  logic              step_ack_i,
   output logic              step_o,
   output logic              step_up_o,
   output logic [PH_W-1:0]   phase_o,
   output logic              done_o,
   output logic              fail_o,
   output logic              busy_o
);

   generate
      if (PH_W < 2 || PH_W > 12) begin : g_bad_ph_w
         $error("phase_eye_cal: PH_W out of range");
      end
      if (RUN_LEN < 1) begin : g_bad_run
         $error("phase_eye_cal: RUN_LEN must be positive");
      end
      if (MIN_WIDTH < 1 || MIN_WIDTH > (1 << PH_W)) begin : g_bad_min
         $error("phase_eye_cal: MIN_WIDTH out of range");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("phase_eye_cal: WORD_W must be positive");
      end
   endgenerate

   logic match_en, match_clr, match_pass, match_miss;
   logic step_req, step_req_up, step_pend, step_fin;

   eye_word_matcher #(
      .WORD_W   (WORD_W),
      .RUN_LEN  (RUN_LEN),
      .REG_INPUT(REG_INPUT),
      .PATTERN  (PATTERN)
   ) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (match_en),
      .clear_i(match_clr),
      .word_i (word_i),
      .valid_i(word_valid_i),
      .pass_o (match_pass),
      .miss_o (match_miss)
   );

   phase_step_tracker #(
      .PH_W(PH_W)
   ) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (step_req),
      .req_up_i (step_req_up),
      .ack_i    (step_ack_i),
      .step_o   (step_o),
      .step_up_o(step_up_o),
      .pending_o(step_pend),
      .stepped_o(step_fin),
      .phase_o  (phase_o)
   );

   eye_sweep_ctrl #(
      .PH_W     (PH_W),
      .MIN_WIDTH(MIN_WIDTH)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .pass_i   (match_pass),
      .miss_i   (match_miss),
      .stepped_i(step_fin && !step_pend),
      .cur_i    (phase_o),
      .req_o    (step_req),
      .req_up_o (step_req_up),
      .clear_o  (match_clr),
      .test_en_o(match_en),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .fail_o   (fail_o)
   );

endmodule

// File: rtl/eye_cal_checks.sv
module eye_cal_checks #(
   parameter int PH_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            step_ack_i,
   input logic            step_o,
   input logic [PH_W-1:0] phase_o,
   input logic            done_o,
   input logic            fail_o,
   input logic            busy_o
);
   logic            outstanding, busy_q, have_cap;
   logic [PH_W-1:0] start_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
         busy_q      <= 1'b0;
         have_cap    <= 1'b0;
         start_cap   <= '0;
      end else begin
         busy_q <= busy_o;
         if (step_o)
            outstanding <= 1'b1;
         else if (step_ack_i)
            outstanding <= 1'b0;
         if (busy_o && !busy_q) begin
            start_cap <= phase_o;
            have_cap  <= 1'b1;
         end
      end
   end

   assert_step_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> !step_o);

   assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> !outstanding);

   assert_phase_moves_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_o) |-> $past(step_ack_i));

   assert_fail_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fail_o && have_cap) |-> (phase_o == start_cap));

   assert_hold_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (done_o && $stable(phase_o) && $stable(fail_o)));

   assert_no_step_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !step_o);

   assert_step_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> busy_o);

   assert_done_busy_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));

endmodule

bind phase_eye_cal eye_cal_checks #(.PH_W(PH_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step_ack_i(step_ack_i),
   .step_o    (step_o),
   .phase_o   (phase_o),
   .done_o    (done_o),
   .fail_o    (fail_o),
   .busy_o    (busy_o)
);

// File: tb/sim_phase_eye_cal.sv
module sim_phase_eye_cal;
   localparam logic [6:0] PAT = 7'h63;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [6:0] word_i = '0;
   logic       word_valid_i = 1'b0;
   logic       step_ack_i = 1'b0;
   logic       step_o, step_up_o, done_o, fail_o, busy_o;
   logic [7:0] phase_o;

   always #2 clk = ~clk;

   phase_eye_cal u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .word_i      (word_i),
      .word_valid_i(word_valid_i),
      .step_ack_i  (step_ack_i),
      .step_o      (step_o),
      .step_up_o   (step_up_o),
      .phase_o     (phase_o),
      .done_o      (done_o),
      .fail_o      (fail_o),
      .busy_o      (busy_o)
   );

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int vcnt = 0;
   int bench_ph = 0;
   int win_lo = 0;
   int win_w = 0;
   bit marg = 0;
   bit valid_en = 1;
   bit pend = 0;
   bit pdir = 0;
   bit step_prev = 0;
   int dly = 0;
   int viol = 0;
   int steps_seen = 0;

   function automatic bit in_win(int p);
      int off;
      off = ((p - win_lo) % 256 + 256) % 256;
      return (win_w > 0) && (off < win_w);
   endfunction

   function automatic bit is_marg(int p);
      return marg && (win_w < 256) && (p == ((win_lo + win_w) % 256));
   endfunction

   // shifter model and link model, driven away from the active edge
   always @(negedge clk) begin
      bit v, good;
      cyc++;
      if (step_o && step_prev) viol++;
      if (step_o && pend) viol++;
      step_prev  = step_o;
      step_ack_i = 1'b0;
      if (pend) begin
         if (dly == 0) begin
            step_ack_i = 1'b1;
            bench_ph   = pdir ? (bench_ph + 1) % 256 : (bench_ph + 255) % 256;
            pend       = 0;
         end else begin
            dly--;
         end
      end
      if (step_o) begin
         pend = 1;
         pdir = step_up_o;
         dly  = 1 + (cyc % 3);
         steps_seen++;
      end
      v = valid_en && (cyc % 4 != 3);
      word_valid_i = v;
      if (v) begin
         vcnt++;
         good   = in_win(bench_ph) || (is_marg(bench_ph) && (vcnt % 40 != 0));
         word_i = good ? PAT : (PAT ^ 7'h10);
      end else begin
         word_i = ~PAT;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      pend = 0; bench_ph = 0; viol = 0; steps_seen = 0; valid_en = 1;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done_o && t < 60000) begin
         @(negedge clk);
         t++;
      end
      check(done_o == 1'b1, "R11 calibration ends", done_o, 1);
   endtask

   task automatic run_case(input int lo, input int w, input bit mg, input string tag);
      int  exp_ph;
      bit  exp_fail;
      do_reset();
      win_lo = lo; win_w = w; marg = mg;
      if (w < 8) begin
         exp_fail = 1; exp_ph = 0;
      end else if (w == 256) begin
         exp_fail = 0; exp_ph = 128;
      end else begin
         exp_fail = 0; exp_ph = (lo + (w - 1) / 2) % 256;
      end
      pulse_start();
      repeat (2) @(negedge clk);
      check(busy_o == 1'b1, "R11 busy during run", busy_o, 1);
      wait_done();
      @(negedge clk);
      check(fail_o == exp_fail, {tag, " fail flag"}, fail_o, exp_fail);
      check(phase_o == exp_ph, {tag, " final phase"}, phase_o, exp_ph);
      check(bench_ph == phase_o, "R2 phase tracks shifter", phase_o, bench_ph);
      check(viol == 0, "R2 step protocol", viol, 0);
      check(busy_o == 1'b0, "R11 busy low at end", busy_o, 0);
   endtask

   initial begin
      int s0, p0;
      repeat (3) @(negedge clk);
      check(step_o == 0 && done_o == 0 && fail_o == 0 && busy_o == 0,
            "R1 reset flags", {step_o, done_o, fail_o, busy_o}, 0);
      check(phase_o == 0, "R1 reset phase", phase_o, 0);

      // upward search then centre
      run_case(40, 30, 0, "R4 R5 search and centre");
      // locked after done
      s0 = steps_seen; p0 = phase_o;
      pulse_start();
      repeat (300) @(negedge clk);
      check(steps_seen == s0, "R10 start ignored steps", steps_seen, s0);
      check(phase_o == p0, "R10 phase held", phase_o, p0);
      check(done_o == 1'b1, "R10 done held", done_o, 1);

      // wrapping window with a marginal setting above it
      run_case(250, 20, 1, "R6 R3 wrap with marginal edge");
      // width limit
      run_case(100, 8, 0, "R7 width of 8 accepted");
      run_case(100, 7, 0, "R7 width of 7 rejected");
      // nothing clean
      run_case(0, 0, 0, "R8 no clean setting");

      // whole circle clean, with a stalled valid strobe first
      do_reset();
      win_lo = 0; win_w = 256; marg = 0;
      valid_en = 0;
      pulse_start();
      repeat (400) @(negedge clk);
      check(steps_seen == 0, "R3 no step without valid words", steps_seen, 0);
      check(busy_o == 1'b1, "R3 still testing without valid words", busy_o, 1);
      valid_en = 1;
      wait_done();
      @(negedge clk);
      check(fail_o == 1'b0, "R9 full circle no fail", fail_o, 0);
      check(phase_o == 128, "R9 full circle phase", phase_o, 128);
      check(bench_ph == phase_o, "R2 phase tracks shifter", phase_o, bench_ph);
      check(viol == 0, "R2 step protocol", viol, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule